// File: doc/BRIEF.md
# Function-Coded 32-bit ALU with Set-Less-Than

This block is a purely combinational arithmetic and logic unit. It takes two operands and a three-bit function code and returns one result word in the same cycle. The upper code bit conditions the second operand. When that bit is set, the operand is bit-inverted and the single shared adder receives a carry-in of one, so that the adder computes `A - B`. The lower two code bits choose one of four result sources: the bitwise AND, the bitwise OR, the adder sum, or the sign of the sum extended with zeros.

Set-less-than reuses the subtract path. It reports the raw top bit of `A - B` and makes no correction for signed overflow. The one code with no defined function returns zero. A zero flag accompanies every result. The adder is a parallel-prefix network, so its carry depth grows with the logarithm of the width.

Top module: `alu3_core`

## Requirements
- R1: Code 3'b000 gives result = op_a AND op_b.
- R2: Code 3'b001 gives result = op_a OR op_b.
- R3: Code 3'b010 gives result = (op_a + op_b) modulo 2^W.
- R4: Code 3'b110 gives result = (op_a + NOT op_b + 1) modulo 2^W, which is op_a - op_b with wraparound.
- R5: Code 3'b100 gives result = op_a AND NOT op_b. The forced carry-in has no effect on this result.
- R6: Code 3'b101 gives result = op_a OR NOT op_b. The forced carry-in has no effect on this result.
- R7: Code 3'b111 gives result bit 0 = bit W-1 of (op_a - op_b), with all other result bits 0. The raw sign is used. For example, 25 versus 32 gives 1, 0x80000000 versus 1 gives 0, and 0x7FFFFFFF versus 0xFFFFFFFF gives 1.
- R8: Code 3'b011 gives result = 0 for every operand pair.
- R9: Output zero is 1 exactly when every result bit is 0, under every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (32) | First operand |
| op_b | input | W (32) | Second operand, inverted when func[2] is 1 |
| func | input | 3 | Function code: bit 2 inverts op_b and sets carry-in, bits 1:0 select the result source |
| result | output | W (32) | Selected result word |
| zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and the main result are produced in the same cycle. They coincide in their hard cases: subtracting equal operands, set-less-than when op_a is not below op_b, the unused code with nonzero operands, and an addition that wraps exactly to zero (1 plus 0xFFFFFFFF). Directed boundary operands provoke each of these cases. Seeded random operands spread the coverage across all eight codes. Every applied vector is judged on both outputs together against a bench model built from the code table.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

    // result source chosen by the lower two function bits
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_SIGN = 2'b11
    } out_sel_e;

    // the one code with no defined function
    localparam logic [2:0] FN_RSVD = 3'b011;

endpackage

// File: rtl/alu3_b_cond.sv
module alu3_b_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_b,
    input  logic         invert,
    output logic [W-1:0] b_eff,
    output logic         carry_in
);
    always_comb begin
        b_eff    = invert ? ~op_b : op_b;
        carry_in = invert;
    end
endmodule

// File: rtl/alu3_bitwise.sv
module alu3_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_v,
    output logic [W-1:0] or_v
);
    always_comb begin
        and_v = a & b;
        or_v  = a | b;
    end
endmodule

// File: rtl/alu3_prefix_adder.sv
module alu3_prefix_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    // carries into bits 1..W-1 depend only on bits 0..W-2
    localparam int N  = W - 1;
    localparam int LV = (N > 1) ? $clog2(N) : 0;

    logic [N-1:0] gen_l [LV+1];
    logic [N-1:0] prp_l [LV+1];
    logic [W-1:0] carry_vec;

    assign gen_l[0] = a[N-1:0] & b[N-1:0];
    assign prp_l[0] = a[N-1:0] | b[N-1:0];

    // Kogge-Stone style levels, span doubles each stage
    for (genvar lv = 0; lv < LV; lv++) begin : g_level
        localparam int D = 1 << lv;
        localparam logic [N-1:0] LOWMASK = {N{1'b1}} >> (N - D);
        assign gen_l[lv+1] = gen_l[lv] | (prp_l[lv] & (gen_l[lv] << D));
        assign prp_l[lv+1] = prp_l[lv] & ((prp_l[lv] << D) | LOWMASK);
    end

    assign carry_vec = {gen_l[LV] | (prp_l[LV] & {N{cin}}), cin};
    assign sum       = a ^ b ^ carry_vec;
endmodule

// File: rtl/alu3_core.sv
module alu3_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   func,
    output logic [W-1:0] result,
    output logic         zero
);
    import alu3_pkg::*;

    typedef struct packed {
        logic [W-1:0] y;
        logic         z;
    } out_t;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] sum_v;
    out_sel_e     sel;
    out_t         out_d;

    alu3_b_cond #(.W(W)) u_bcond (
        .op_b     (op_b),
        .invert   (func[2]),
        .b_eff    (b_eff),
        .carry_in (cin)
    );

    alu3_bitwise #(.W(W)) u_bitw (
        .a     (op_a),
        .b     (b_eff),
        .and_v (and_v),
        .or_v  (or_v)
    );

    alu3_prefix_adder #(.W(W)) u_add (
        .a   (op_a),
        .b   (b_eff),
        .cin (cin),
        .sum (sum_v)
    );

    assign sel = out_sel_e'(func[1:0]);

    always_comb begin
        out_d.y = '0;
        unique case (sel)
            SEL_AND:  out_d.y = and_v;
            SEL_OR:   out_d.y = or_v;
            SEL_SUM:  out_d.y = sum_v;
            SEL_SIGN: out_d.y = {{(W-1){1'b0}}, sum_v[W-1]};
        endcase
        if (func == FN_RSVD) begin
            out_d.y = '0;
        end
        out_d.z = (out_d.y == '0);
    end

    assign result = out_d.y;
    assign zero   = out_d.z;
endmodule

// File: rtl/alu3_chk.sv
module alu3_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   func,
    input logic [W-1:0] result,
    input logic         zero
);
    always_comb begin
        // R3
        if (func == 3'b010) begin
            add_inverse_chk: assert (result - op_b == op_a)
                else $error("add result does not invert");
        end
        // R4
        if (func == 3'b110) begin
            sub_inverse_chk: assert (result + op_b == op_a)
                else $error("sub result does not invert");
        end
        // R7
        if (func == 3'b111) begin
            slt_upper_clear_chk: assert (result[W-1:1] == '0)
                else $error("slt upper bits set");
        end
        // R8
        if (func == 3'b011) begin
            rsvd_zero_chk: assert (result == '0 && zero)
                else $error("reserved code nonzero");
        end
        // R9
        zero_flag_chk: assert (zero == (result == '0))
            else $error("zero flag mismatch");
    end
endmodule

bind alu3_core alu3_chk #(.W(W)) u_alu3_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .func   (func),
    .result (result),
    .zero   (zero)
);

// File: tb/tb_alu3_core.sv
module tb_alu3_core;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   func = 3'b000;
    logic [W-1:0] result;
    logic         zero;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    alu3_core #(.W(W)) dut (
        .op_a   (op_a),
        .op_b   (op_b),
        .func   (func),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [2:0] f);
        logic [W-1:0] diff;
        diff = a + ~b + 1;
        case (f)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b100:  return a & ~b;
            3'b101:  return a | ~b;
            3'b110:  return diff;
            3'b111:  return {{(W-1){1'b0}}, diff[W-1]};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R4";
            3'b111:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] f);
        logic [W-1:0] exp_y;
        @(posedge clk);
        op_a <= a;
        op_b <= b;
        func <= f;
        @(negedge clk);
        exp_y = model(a, b, f);
        tests++;
        if (result !== exp_y) begin
            fails++;
            $display("FAIL %s f=%b a=%h b=%h got %h expected %h",
                     req_of(f), f, a, b, result, exp_y);
        end
        tests++;
        if (zero !== (exp_y == '0)) begin
            fails++;
            $display("FAIL R9 f=%b a=%h b=%h got %b expected %b",
                     f, a, b, zero, (exp_y == '0));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got running expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] corners [5];
        int unsigned seed_v;
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF;
        seed_v = $urandom(32'd20240917);

        // initial state: all-zero inputs give zero result and flag (R1, R9)
        apply('0, '0, 3'b000);

        // R7 directed: 25 < 32 gives 1; raw-sign cases
        apply(32'd25, 32'd32, 3'b111);
        apply(32'h8000_0000, 32'h0000_0001, 3'b111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        // R4 + R9: equal operands subtract to zero
        apply(32'h1234_5678, 32'h1234_5678, 3'b110);
        // R3 + R9: wrap to exactly zero
        apply(32'h0000_0001, 32'hFFFF_FFFF, 3'b010);
        // R8: unused code with nonzero operands
        apply(32'hDEAD_BEEF, 32'h0BAD_F00D, 3'b011);
        // R5, R6: carry-in must not leak into bitwise results
        apply(32'h0000_0000, 32'hFFFF_FFFF, 3'b100);
        apply(32'h0000_0000, 32'hFFFF_FFFF, 3'b101);

        // boundary operand grid on every code
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    apply(corners[i], corners[j], 3'(f));
                end
            end
        end

        // seeded random operands on every code
        for (int k = 0; k < 1600; k++) begin
            apply($urandom, $urandom, 3'(k % 8));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule